// File: doc/BRIEF.md
# Privileged Alignment-Flag Clear Unit

This unit watches a byte-serial instruction stream, one byte per clock while a valid strobe is high, and recognises a three-byte, operand-free instruction whose only job is to drop the alignment-check flag. The unit owns the 32-bit flags register. When the instruction completes, it either commits the flag update or raises an invalid-opcode fault. Which of the two happens depends on the processor mode, the current privilege level, a LOCK prefix, and the supervisor-access-protection enable bit in a 32-bit feature word.

The rest of the core can overwrite the flags register through a load port. If a load and a commit land on the same edge, the clear is applied on top of the loaded value. Fetch, fault delivery, other opcodes and other prefixes are handled elsewhere.

Top module: `clac_unit`

## Requirements
- R1: While rstN is low, and on the first cycle after it rises, flags reads 0x00000002 and commitPulse and faultPulse are 0.
- R2: Only the byte run 0x0F, 0x01, 0xCA is accepted as the instruction. Cycles with byteValid low may fall between its bytes. Each matched instruction gives exactly one of commitPulse or faultPulse for one cycle, in the cycle right after the edge that samples the 0xCA byte. No pulse appears at any other time.
- R3: On a commit, flags bit 18 becomes 0 and every other flag bit keeps its value.
- R4: On a fault, flags does not change.
- R5: A LOCK prefix byte 0xF0 ahead of the opcode causes a fault in every mode.
- R6: mode codes are 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit; codes 5 to 7 behave like protected. In every mode except real, a cpl other than 0 causes a fault. In real mode, cpl is ignored.
- R7: In virtual-8086 mode (code 2) the instruction always faults.
- R8: When featureWord bit 20 is 0, the instruction faults in every mode.
- R9: If a 0x66, 0xF2 or 0xF3 byte appears among the prefixes, the sequence is not this instruction. There is no pulse and flags is unchanged.
- R10: An unexpected byte after 0x0F, or after 0x0F 0x01, ends the partial match with no pulse. That byte is discarded, and the next byte is decoded from idle.
- R11: flagsLoad writes flagsIn into flags on the next edge. If a load lands on the final byte's edge, a commit clears bit 18 of the loaded value and a fault keeps the loaded value. Without a load or a commit, flags holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| byteValid | input | 1 | Instruction byte strobe |
| byteData | input | 8 | Instruction byte |
| cpl | input | 2 | Current privilege level |
| mode | input | 3 | Processor mode code |
| featureWord | input | 32 | Feature word; bit 20 enables the instruction |
| flagsLoad | input | 1 | Overwrite flags with flagsIn |
| flagsIn | input | 32 | Value for a flags load |
| flags | output | 32 | Flags register |
| commitPulse | output | 1 | Instruction committed |
| faultPulse | output | 1 | Invalid-opcode fault |

## Verification
A flags load from the surrounding core and the retirement of the instruction can share one clock edge. The bench provokes this by raising flagsLoad, with bit 18 set in flagsIn, in the very cycle that presents the 0xCA byte. It does so in both directed and random runs, under conditions that lead to a commit and under conditions that lead to a fault. It judges the result against a bench model: bit 18 cleared from the loaded value on a commit, the loaded value intact on a fault.

// File: rtl/clac_pkg.sv
package clac_pkg;
  localparam logic [7:0] BYTE_ESC   = 8'h0F;
  localparam logic [7:0] BYTE_GRP   = 8'h01;
  localparam logic [7:0] BYTE_FINAL = 8'hCA;
  localparam logic [7:0] BYTE_LOCK  = 8'hF0;
  localparam logic [7:0] BYTE_OPSZ  = 8'h66;
  localparam logic [7:0] BYTE_REPN  = 8'hF2;
  localparam logic [7:0] BYTE_REP   = 8'hF3;

  localparam logic [2:0] MODE_REAL   = 3'd0;
  localparam logic [2:0] MODE_PROT   = 3'd1;
  localparam logic [2:0] MODE_V86    = 3'd2;
  localparam logic [2:0] MODE_COMPAT = 3'd3;
  localparam logic [2:0] MODE_LONG   = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_GOT_ESC,
    ST_GOT_GRP
  } matchState_e;

  typedef struct packed {
    logic clearAc;
    logic fault;
  } ctrlStrobe_t;
endpackage

// File: rtl/clac_ctrl.sv
module clac_ctrl
  import clac_pkg::*;
#(
  parameter int FEAT_WIDTH = 32,
  parameter int FEAT_BIT   = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  byteValid,
  input  logic [7:0]            byteData,
  input  logic [1:0]            cpl,
  input  logic [2:0]            mode,
  input  logic [FEAT_WIDTH-1:0] featureWord,
  output ctrlStrobe_t           strobe
);
  matchState_e stateQ, stateD;
  logic lockSeenQ, lockSeenD;
  logic mandSeenQ, mandSeenD;
  logic faultCond;

  assign faultCond = !featureWord[FEAT_BIT]
                   || (mode == MODE_V86)
                   || lockSeenQ
                   || ((mode != MODE_REAL) && (cpl != 2'd0));

  always_comb begin
    stateD    = stateQ;
    lockSeenD = lockSeenQ;
    mandSeenD = mandSeenQ;
    strobe    = '0;
    if (byteValid) begin
      unique case (stateQ)
        ST_IDLE: begin
          if (byteData == BYTE_LOCK) begin
            lockSeenD = 1'b1;
          end else if (byteData == BYTE_OPSZ || byteData == BYTE_REPN ||
                       byteData == BYTE_REP) begin
            mandSeenD = 1'b1;
          end else if (byteData == BYTE_ESC) begin
            stateD = ST_GOT_ESC;
          end else begin
            lockSeenD = 1'b0;
            mandSeenD = 1'b0;
          end
        end
        ST_GOT_ESC: begin
          if (byteData == BYTE_GRP) begin
            stateD = ST_GOT_GRP;
          end else begin
            stateD    = ST_IDLE;
            lockSeenD = 1'b0;
            mandSeenD = 1'b0;
          end
        end
        ST_GOT_GRP: begin
          stateD    = ST_IDLE;
          lockSeenD = 1'b0;
          mandSeenD = 1'b0;
          if (byteData == BYTE_FINAL && !mandSeenQ) begin
            strobe.fault   = faultCond;
            strobe.clearAc = !faultCond;
          end
        end
        default: begin
          stateD    = ST_IDLE;
          lockSeenD = 1'b0;
          mandSeenD = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      lockSeenQ <= 1'b0;
      mandSeenQ <= 1'b0;
    end else begin
      stateQ    <= stateD;
      lockSeenQ <= lockSeenD;
      mandSeenQ <= mandSeenD;
    end
  end
endmodule

// File: rtl/clac_datapath.sv
module clac_datapath
  import clac_pkg::*;
#(
  parameter int               FLAG_WIDTH = 32,
  parameter int               AC_BIT     = 18,
  parameter logic [31:0]      RESET_VAL  = 32'h0000_0002
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic                  flagsLoad,
  input  logic [FLAG_WIDTH-1:0] flagsIn,
  output logic [FLAG_WIDTH-1:0] flagsQ,
  output logic                  commitQ,
  output logic                  faultQ
);
  localparam logic [FLAG_WIDTH-1:0] AC_MASK = FLAG_WIDTH'(1) << AC_BIT;

  logic [FLAG_WIDTH-1:0] flagsBase;
  logic [FLAG_WIDTH-1:0] flagsNext;

  always_comb begin
    flagsBase = flagsLoad ? flagsIn : flagsQ;
    flagsNext = strobe.clearAc ? (flagsBase & ~AC_MASK) : flagsBase;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagsQ  <= RESET_VAL[FLAG_WIDTH-1:0];
      commitQ <= 1'b0;
      faultQ  <= 1'b0;
    end else begin
      flagsQ  <= flagsNext;
      commitQ <= strobe.clearAc;
      faultQ  <= strobe.fault;
    end
  end
endmodule

// File: rtl/clac_unit.sv
module clac_unit
  import clac_pkg::*;
#(
  parameter int          FLAG_WIDTH = 32,
  parameter int          AC_BIT     = 18,
  parameter logic [31:0] RESET_VAL  = 32'h0000_0002,
  parameter int          FEAT_WIDTH = 32,
  parameter int          FEAT_BIT   = 20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  byteValid,
  input  logic [7:0]            byteData,
  input  logic [1:0]            cpl,
  input  logic [2:0]            mode,
  input  logic [FEAT_WIDTH-1:0] featureWord,
  input  logic                  flagsLoad,
  input  logic [FLAG_WIDTH-1:0] flagsIn,
  output logic [FLAG_WIDTH-1:0] flags,
  output logic                  commitPulse,
  output logic                  faultPulse
);
  ctrlStrobe_t strobe;

  clac_ctrl #(
    .FEAT_WIDTH(FEAT_WIDTH),
    .FEAT_BIT  (FEAT_BIT)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .cpl        (cpl),
    .mode       (mode),
    .featureWord(featureWord),
    .strobe     (strobe)
  );

  clac_datapath #(
    .FLAG_WIDTH(FLAG_WIDTH),
    .AC_BIT    (AC_BIT),
    .RESET_VAL (RESET_VAL)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .flagsLoad(flagsLoad),
    .flagsIn  (flagsIn),
    .flagsQ   (flags),
    .commitQ  (commitPulse),
    .faultQ   (faultPulse)
  );
endmodule

// File: rtl/clac_unit_checker.sv
module clac_unit_checker
  import clac_pkg::*;
#(
  parameter int          FLAG_WIDTH = 32,
  parameter int          AC_BIT     = 18,
  parameter logic [31:0] RESET_VAL  = 32'h0000_0002,
  parameter int          FEAT_WIDTH = 32,
  parameter int          FEAT_BIT   = 20
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  byteValid,
  input logic [7:0]            byteData,
  input logic [1:0]            cpl,
  input logic [2:0]            mode,
  input logic [FEAT_WIDTH-1:0] featureWord,
  input logic                  flagsLoad,
  input logic [FLAG_WIDTH-1:0] flagsIn,
  input logic [FLAG_WIDTH-1:0] flags,
  input logic                  commitPulse,
  input logic                  faultPulse
);
  localparam logic [FLAG_WIDTH-1:0] AC_MASK = FLAG_WIDTH'(1) << AC_BIT;

  a_r1_reset_state: assert property (@(posedge clk)
    !rstN |=> (flags == RESET_VAL[FLAG_WIDTH-1:0] && !commitPulse && !faultPulse));

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    !(commitPulse && faultPulse));

  a_r2_after_final: assert property (@(posedge clk) disable iff (!rstN)
    (commitPulse || faultPulse) |-> $past(byteValid && byteData == BYTE_FINAL));

  a_r3_clear_only_ac: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> flags == (($past(flagsLoad) ? $past(flagsIn) : $past(flags)) & ~AC_MASK));

  a_r4_fault_keeps: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> flags == ($past(flagsLoad) ? $past(flagsIn) : $past(flags)));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!commitPulse && !$past(flagsLoad)) |-> $stable(flags));

  a_r6_privilege: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> ($past(mode) == MODE_REAL || $past(cpl) == 2'd0));

  a_r7_no_v86: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $past(mode) != MODE_V86);

  a_r8_feature: assert property (@(posedge clk) disable iff (!rstN)
    commitPulse |-> $past(featureWord[FEAT_BIT]));
endmodule

bind clac_unit clac_unit_checker #(
  .FLAG_WIDTH(FLAG_WIDTH),
  .AC_BIT    (AC_BIT),
  .RESET_VAL (RESET_VAL),
  .FEAT_WIDTH(FEAT_WIDTH),
  .FEAT_BIT  (FEAT_BIT)
) uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .byteValid  (byteValid),
  .byteData   (byteData),
  .cpl        (cpl),
  .mode       (mode),
  .featureWord(featureWord),
  .flagsLoad  (flagsLoad),
  .flagsIn    (flagsIn),
  .flags      (flags),
  .commitPulse(commitPulse),
  .faultPulse (faultPulse)
);

// File: tb/clac_unit_test.sv
module clac_unit_test;
  localparam logic [31:0] AC = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'h00;
  logic [1:0]  cpl = 2'd0;
  logic [2:0]  mode = 3'd4;
  logic [31:0] featureWord = 32'h0010_0000;
  logic        flagsLoad = 1'b0;
  logic [31:0] flagsIn = 32'h0;
  logic [31:0] flags;
  logic        commitPulse, faultPulse;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] expFlags = 32'h2;
  logic lastCommit, lastFault;
  logic [31:0] lastFlags;

  clac_unit uut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .cpl(cpl), .mode(mode), .featureWord(featureWord),
    .flagsLoad(flagsLoad), .flagsIn(flagsIn), .flags(flags),
    .commitPulse(commitPulse), .faultPulse(faultPulse)
  );

  always #5 clk = ~clk;

  function automatic logic expFault(input logic lk, input logic [2:0] md,
                                    input logic [1:0] pl, input logic ft);
    return !ft || (md == 3'd2) || lk || (md != 3'd0 && pl != 2'd0);
  endfunction

  task automatic check(input logic ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic ld, input logic [31:0] v);
    @(negedge clk);
    byteValid = 1'b1; byteData = b; flagsLoad = ld; flagsIn = v;
    @(posedge clk); #1;
    byteValid = 1'b0; flagsLoad = 1'b0;
    lastCommit = commitPulse; lastFault = faultPulse; lastFlags = flags;
  endtask

  task automatic loadFlags(input logic [31:0] v);
    @(negedge clk);
    flagsLoad = 1'b1; flagsIn = v;
    @(posedge clk); #1;
    flagsLoad = 1'b0;
    expFlags = v;
    check(flags == v, "R11 load", {32'h0, flags}, {32'h0, v});
  endtask

  task automatic runInstr(input logic lk, input logic md, input logic [2:0] mo,
                          input logic [1:0] pl, input logic ft, input logic gap,
                          input logic ldSame, input logic [31:0] ldVal);
    logic early = 1'b0;
    logic expC, expF, flt;
    logic [31:0] base;
    string tag;
    @(negedge clk);
    mode = mo; cpl = pl;
    featureWord = ($urandom & ~32'h0010_0000) | (ft ? 32'h0010_0000 : 32'h0);
    if (md) begin
      sendByte(($urandom % 3 == 0) ? 8'h66 : (($urandom % 2) ? 8'hF2 : 8'hF3), 1'b0, 0);
      early |= lastCommit | lastFault;
    end
    if (lk) begin sendByte(8'hF0, 1'b0, 0); early |= lastCommit | lastFault; end
    sendByte(8'h0F, 1'b0, 0); early |= lastCommit | lastFault;
    if (gap) @(negedge clk);
    sendByte(8'h01, 1'b0, 0); early |= lastCommit | lastFault;
    if (gap) begin @(negedge clk); @(negedge clk); end
    sendByte(8'hCA, ldSame, ldVal);
    base = ldSame ? ldVal : expFlags;
    flt = expFault(lk, mo, pl, ft);
    expC = !md && !flt;
    expF = !md && flt;
    expFlags = expC ? (base & ~AC) : base;
    if (md) tag = "R9";
    else if (!ft) tag = "R8";
    else if (mo == 3'd2) tag = "R7";
    else if (lk) tag = "R5";
    else if (pl != 0) tag = "R6";
    else tag = "R3";
    if (ldSame) tag = {tag, "/R11"};
    check(!early, "R2 early pulse", {63'h0, early}, 64'h0);
    check(lastCommit == expC && lastFault == expF, {tag, " R2 outcome"},
          {62'h0, lastCommit, lastFault}, {62'h0, expC, expF});
    check(lastFlags == expFlags, {tag, " R4 flags"},
          {32'h0, lastFlags}, {32'h0, expFlags});
  endtask

  initial begin : watchdog
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check(flags == 32'h2 && !commitPulse && !faultPulse, "R1 during reset",
          {30'h0, commitPulse, faultPulse, flags}, {32'h0, 32'h2});
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check(flags == 32'h2 && !commitPulse && !faultPulse, "R1 after reset",
          {30'h0, commitPulse, faultPulse, flags}, {32'h0, 32'h2});

    loadFlags(32'hA5A5_A5A7 | AC);
    runInstr(0, 0, 3'd4, 2'd0, 1, 0, 0, 0);            // R3 commit, 64-bit
    loadFlags(32'hFFFF_FFFF);
    runInstr(0, 0, 3'd0, 2'd3, 1, 1, 0, 0);            // R6 real mode ignores cpl
    loadFlags(32'h0004_0002);
    runInstr(0, 0, 3'd1, 2'd1, 1, 0, 0, 0);            // R6 protected cpl>0
    runInstr(0, 0, 3'd3, 2'd2, 1, 0, 0, 0);            // R6 compat cpl>0
    runInstr(0, 0, 3'd6, 2'd3, 1, 0, 0, 0);            // R6 reserved code
    runInstr(0, 0, 3'd2, 2'd0, 1, 0, 0, 0);            // R7 v86
    runInstr(1, 0, 3'd0, 2'd0, 1, 0, 0, 0);            // R5 lock real
    runInstr(0, 0, 3'd4, 2'd0, 0, 0, 0, 0);            // R8 feature off
    runInstr(0, 1, 3'd4, 2'd0, 1, 0, 0, 0);            // R9 mandatory prefix
    runInstr(0, 0, 3'd4, 2'd0, 1, 0, 1, 32'h1234_5677 | AC); // R11 commit + load
    runInstr(1, 0, 3'd4, 2'd0, 1, 0, 1, 32'h0F0F_0F0F | AC); // R11 fault + load

    // R10: broken partial matches, then a clean instruction
    loadFlags(32'h0004_0202);
    sendByte(8'h0F, 0, 0); sendByte(8'h02, 0, 0);
    check(!lastCommit && !lastFault && lastFlags == expFlags, "R10 break after 0F",
          {30'h0, lastCommit, lastFault, lastFlags}, {32'h0, expFlags});
    sendByte(8'h0F, 0, 0); sendByte(8'h01, 0, 0); sendByte(8'hCB, 0, 0);
    check(!lastCommit && !lastFault && lastFlags == expFlags, "R10 break after 01",
          {30'h0, lastCommit, lastFault, lastFlags}, {32'h0, expFlags});
    sendByte(8'h0F, 0, 0); sendByte(8'h0F, 0, 0); sendByte(8'h01, 0, 0);
    check(!lastCommit && !lastFault, "R10 breaking byte discarded",
          {62'h0, lastCommit, lastFault}, 64'h0);
    sendByte(8'hCA, 0, 0);
    check(!lastCommit && !lastFault, "R10 no match from discarded byte",
          {62'h0, lastCommit, lastFault}, 64'h0);
    runInstr(0, 0, 3'd4, 2'd0, 1, 0, 0, 0);

    for (int i = 0; i < 300; i++) begin
      if ($urandom % 3 == 0) loadFlags($urandom | AC);
      runInstr(($urandom % 5) == 0, ($urandom % 7) == 0, 3'($urandom % 8),
               2'($urandom % 4), ($urandom % 6) != 0, $urandom % 2,
               ($urandom % 5) == 0, $urandom | AC);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule